// File: doc/BRIEF.md
# Thermal Camera Line Packet Capture

This block sits behind the serial receiver of a thermal camera's video link and turns its byte stream into pixels in an on-chip frame store. The stream is a run of fixed-length packets of 164 bytes. Each packet starts with a two-byte identifier, sent most significant byte first, and a two-byte checksum. After that come 160 payload bytes, which hold 80 pixels of 16 bits each. The block finds the start of a frame from the identifier, writes each pixel of accepted packets to the store and checks the checksum once the packet is complete. It pulses a flag when a whole frame has arrived in order.

A strobe from the serial front end marks each packet boundary (the chip-select edge). The strobe restarts the byte position, so a lost or extra byte corrupts one packet at most. The parameter `HIRES` selects the larger mode. In that mode each image line of 160 pixels comes as two packets in a row, and a frame is 120 lines, so it holds 240 packets. The packet number still sets the address, and the address is packet × 80 + pixel.

Top module: `spi_line_capture`

## Requirements
- R1: After reset, `synced`, `wr_en`, `crc_error` and `frame_done` are low, and no write takes place until a packet has been accepted.
- R2: While not synced, a packet is only accepted when its line number (identifier bits 11:0) is 0. Packets with any other line number produce no write and leave `synced` low.
- R3: For an accepted packet, payload bytes 2k and 2k+1 form pixel k, with the first byte as the upper half. The pixel is written to address line × 80 + k, one cycle after its second byte.
- R4: A packet with 0xF in identifier bits 11:8 is a discard packet. It produces no write, has no checksum check, and leaves `synced` and the expected line unchanged.
- R5: The checksum is CRC-16 with polynomial 0x1021 and initial value 0. It is computed over all 164 bytes, with identifier bits 15:12 and both checksum bytes taken as zero, and it is sent in bytes 2 and 3, upper byte first. On a mismatch in an accepted packet, `crc_error` pulses for one cycle and `synced` goes low.
- R6: A packet that is not a discard packet and whose line number is neither 0 nor the previous good line + 1 is not written. If the block was synced, `synced` drops once the identifier has been received.
- R7: `frame_done` pulses for one cycle after the last line of the frame (line 59 by default) ends with a good checksum. At the same edge `synced` goes low, so the block waits for the next line 0.
- R8: `pkt_start` sets the byte position to 0, and a byte in the same cycle is taken as byte 0. A packet cut short by an early strobe can be followed by a complete resend of the same line, which is then accepted.
- R9: Identifier bits 15:12 have no effect on the line number or on the checksum result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | Packet boundary strobe from the serial front end |
| byte_valid | input | 1 | `byte_data` holds a received byte |
| byte_data | input | 8 | Received byte |
| wr_en | output | 1 | Frame store write enable |
| wr_addr | output | ADDR_W (13) | Frame store pixel address |
| wr_data | output | 16 | Pixel value |
| synced | output | 1 | Locked onto a frame in progress |
| crc_error | output | 1 | One-cycle pulse on checksum mismatch |
| frame_done | output | 1 | One-cycle pulse when a frame is complete |

## Verification
Complete frames are sent with random pixels, random idle gaps and random values in the upper identifier bits. Discard packets are mixed in between the lines. Comparing the whole store against the model shows up byte order and address faults, and it also shows whether the upper identifier bits leak into the line number or the checksum. Several streams probe the frame lock:
- Lines sent before any line 0 show whether the hunting rule is kept.
- A packet with a corrupted checksum and a skipped line number each show whether lock is dropped and later writes are stopped.
- A truncated packet followed by its resend shows that the packet strobe restarts the byte position.

// File: rtl/spi_line_capture.sv
module spi_line_capture #(
  parameter int PKT_PX     = 80,
  parameter int BASE_LINES = 60,
  parameter bit HIRES      = 1'b0,
  localparam int PKTS      = HIRES ? 4*BASE_LINES : BASE_LINES,
  localparam int ADDR_W    = $clog2(PKTS*PKT_PX)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_start,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [15:0]       wr_data,
  output logic              synced,
  output logic              crc_error,
  output logic              frame_done
);
  localparam int PKT_BYTES = 4 + 2*PKT_PX;
  localparam int CW        = $clog2(PKT_BYTES+1);

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--)
      r = (r[15] ^ b[i]) ? ({r[14:0], 1'b0} ^ 16'h1021) : {r[14:0], 1'b0};
    return r;
  endfunction

  logic [CW-1:0]     cnt, pos;
  logic [7:0]        id_top, hi_b, crc_in;
  logic [11:0]       line_id, exp_id, cur_id;
  logic [15:0]       crc_acc, crc_rx, crc_nx;
  logic [ADDR_W-1:0] base;
  logic              take, locked, discard_id, accept, take_eff, last_byte;

  assign pos        = pkt_start ? '0 : cnt;
  assign take_eff   = take && !pkt_start;
  assign cur_id     = {id_top[3:0], byte_data};
  assign discard_id = id_top[3:0] == 4'hF;
  assign accept     = !discard_id && (cur_id == 12'd0 || (locked && cur_id == exp_id));
  assign crc_in     = (pos == CW'(0)) ? {4'h0, byte_data[3:0]} :
                      (pos == CW'(2) || pos == CW'(3)) ? 8'h00 : byte_data;
  assign crc_nx     = crc_step((pos == CW'(0)) ? 16'h0000 : crc_acc, crc_in);
  assign last_byte  = pos == CW'(PKT_BYTES-1);
  assign synced     = locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      id_top     <= '0;
      hi_b       <= '0;
      line_id    <= '0;
      exp_id     <= '0;
      crc_acc    <= '0;
      crc_rx     <= '0;
      base       <= '0;
      take       <= 1'b0;
      locked     <= 1'b0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      crc_error  <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      wr_en      <= 1'b0;
      crc_error  <= 1'b0;
      frame_done <= 1'b0;
      if (pkt_start) begin
        cnt  <= '0;
        take <= 1'b0;
      end
      if (byte_valid && pos < CW'(PKT_BYTES)) begin
        cnt     <= pos + CW'(1);
        crc_acc <= crc_nx;
        if (pos == CW'(0)) begin
          id_top <= byte_data;
        end else if (pos == CW'(1)) begin
          take    <= accept;
          line_id <= cur_id;
          base    <= ADDR_W'(int'(cur_id) * PKT_PX);
          if (accept && cur_id == 12'd0)
            locked <= 1'b1;
          else if (!discard_id && !accept)
            locked <= 1'b0;
        end else if (pos == CW'(2)) begin
          crc_rx[15:8] <= byte_data;
        end else if (pos == CW'(3)) begin
          crc_rx[7:0] <= byte_data;
        end else if (!pos[0]) begin
          hi_b <= byte_data;
        end else if (take_eff) begin
          wr_en   <= 1'b1;
          wr_data <= {hi_b, byte_data};
          wr_addr <= base + ADDR_W'((pos - CW'(4)) >> 1);
        end
        if (last_byte && take_eff) begin
          if (crc_nx == crc_rx) begin
            if (line_id == 12'(PKTS-1)) begin
              frame_done <= 1'b1;
              locked     <= 1'b0;
            end else begin
              exp_id <= line_id + 12'd1;
            end
          end else begin
            crc_error <= 1'b1;
            locked    <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_line_capture_chk.sv
module spi_line_capture_chk #(
  parameter int NWORDS = 4800,
  parameter int AW     = 13
)(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          synced,
  input logic          crc_error,
  input logic          frame_done
);
  assert_addr_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> int'(wr_addr) < NWORDS);
  assert_done_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  assert_done_unlocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !synced);
  assert_crc_unlocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    crc_error |-> !synced);
  assert_crc_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    crc_error |=> !crc_error);
  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(crc_error && frame_done));
endmodule

bind spi_line_capture spi_line_capture_chk #(.NWORDS(PKTS*PKT_PX), .AW(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .synced(synced), .crc_error(crc_error), .frame_done(frame_done)
);

// File: tb/test_spi_line_capture.sv
`timescale 1ns/1ps
module test_spi_line_capture;
  localparam int NPX   = 80;
  localparam int NLN   = 60;
  localparam int NPIX  = NPX*NLN;
  localparam int AW    = 13;

  logic clk = 1'b0, rst_n = 1'b0, pkt_start = 1'b0, byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic wr_en, synced, crc_error, frame_done;
  logic [AW-1:0] wr_addr;
  logic [15:0] wr_data;

  spi_line_capture i_spi_line_capture (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .byte_valid(byte_valid),
    .byte_data(byte_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .synced(synced), .crc_error(crc_error), .frame_done(frame_done));

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  int wr_count = 0, done_count = 0, err_count = 0;
  logic [15:0] got_mem [NPIX];
  logic [15:0] exp_mem [NPIX];
  bit force_abcd = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        wr_count++;
        if (int'(wr_addr) < NPIX) got_mem[wr_addr] = wr_data;
      end
      if (frame_done) done_count++;
      if (crc_error) err_count++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] crc8(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--)
      r = (r[15] ^ b[i]) ? ({r[14:0], 1'b0} ^ 16'h1021) : {r[14:0], 1'b0};
    return r;
  endfunction

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      byte_valid = 1'b0;
      pkt_start  = 1'b0;
    end
  endtask

  task automatic send_pkt(input logic [15:0] idf, input bit upd, input int nbytes, input bit corrupt);
    logic [7:0] pk [164];
    logic [15:0] c, p;
    pk[0] = idf[15:8];
    pk[1] = idf[7:0];
    pk[2] = 8'h00;
    pk[3] = 8'h00;
    for (int k = 0; k < NPX; k++) begin
      p = 16'($urandom);
      if (force_abcd && idf[11:0] == 12'd0 && k == 0) p = 16'hABCD;
      pk[4+2*k] = p[15:8];
      pk[5+2*k] = p[7:0];
      if (upd && idf[11:8] != 4'hF) exp_mem[int'(idf[11:0])*NPX + k] = p;
    end
    c = 16'h0000;
    for (int i = 0; i < 164; i++)
      c = crc8(c, (i == 0) ? {4'h0, pk[0][3:0]} : pk[i]);
    pk[2] = c[15:8];
    pk[3] = c[7:0];
    if (corrupt) pk[40] = pk[40] ^ 8'h10;
    for (int i = 0; i < nbytes; i++) begin
      @(negedge clk);
      pkt_start  = (i == 0);
      byte_valid = 1'b1;
      byte_data  = pk[i];
      if ($urandom_range(3) == 0) begin
        @(negedge clk);
        pkt_start  = 1'b0;
        byte_valid = 1'b0;
      end
    end
    idle(2);
  endtask

  function automatic logic [15:0] mk_id(input int line);
    return {4'($urandom), 12'(line)};
  endfunction

  task automatic send_frame(input bit with_trunc);
    for (int l = 0; l < NLN; l++) begin
      if ($urandom_range(4) == 0) send_pkt({4'($urandom), 4'hF, 8'($urandom)}, 1'b0, 164, 1'b0);
      if (with_trunc && l == 7) send_pkt(mk_id(l), 1'b0, 50, 1'b0);
      send_pkt(mk_id(l), 1'b1, 164, 1'b0);
    end
    idle(4);
  endtask

  task automatic cmp_mem(input string req);
    int miss = 0, first = -1;
    for (int a = 0; a < NPIX; a++)
      if (got_mem[a] !== exp_mem[a]) begin
        miss++;
        if (first < 0) first = a;
      end
    chk(miss == 0, req, "frame store mismatch count", miss, 0);
    if (first >= 0)
      $display("  first mismatch addr %0d actual=%h expected=%h", first, got_mem[first], exp_mem[first]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w0, d0, e0;
    void'($urandom(32'd1234));
    for (int a = 0; a < NPIX; a++) begin
      got_mem[a] = 16'h0;
      exp_mem[a] = 16'h0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!synced && !wr_en && !crc_error && !frame_done, "R1", "outputs after reset", int'(synced) + int'(wr_en), 0);
    rst_n = 1'b1;
    idle(3);
    chk(wr_count == 0, "R1", "writes after reset release", wr_count, 0);

    // R2 hunting: non-zero lines before any line 0
    send_pkt(mk_id(5), 1'b0, 164, 1'b0);
    send_pkt(mk_id(6), 1'b0, 164, 1'b0);
    chk(wr_count == 0, "R2", "writes while hunting", wr_count, 0);
    chk(!synced, "R2", "synced while hunting", int'(synced), 0);

    // R4 discard packet while hunting
    send_pkt(16'h0F00, 1'b0, 164, 1'b0);
    chk(wr_count == 0 && !synced, "R4", "discard packet while hunting", wr_count, 0);

    // full frame with truncated resend (R8), random top bits (R9), directed pixel (R3)
    force_abcd = 1'b1;
    send_frame(1'b1);
    force_abcd = 1'b0;
    chk(done_count == 1, "R7", "frame_done pulses after good frame", done_count, 1);
    chk(err_count == 0, "R9", "crc errors with random top identifier bits", err_count, 0);
    cmp_mem("R3");
    chk(got_mem[0] == 16'hABCD, "R3", "upper byte first at line 0 pixel 0", int'(got_mem[0]), 16'hABCD);
    chk(wr_count == NPIX + 23, "R8", "write count including cut packet", wr_count, NPIX + 23);
    chk(!synced, "R7", "synced after frame complete", int'(synced), 0);

    // R4 discard mid-frame keeps sync and writes nothing
    send_pkt(mk_id(0), 1'b0, 164, 1'b0);
    send_pkt(mk_id(1), 1'b0, 164, 1'b0);
    w0 = wr_count;
    send_pkt({4'h2, 4'hF, 8'h3C}, 1'b0, 164, 1'b0);
    chk(wr_count == w0, "R4", "writes during discard packet", wr_count - w0, 0);
    chk(synced, "R4", "sync kept across discard packet", int'(synced), 1);
    w0 = wr_count;
    send_pkt(mk_id(2), 1'b0, 164, 1'b0);
    chk(wr_count == w0 + NPX, "R4", "next line accepted after discard", wr_count - w0, NPX);

    // R5 checksum error on line 3
    e0 = err_count;
    d0 = done_count;
    send_pkt(mk_id(3), 1'b0, 164, 1'b1);
    chk(err_count == e0 + 1, "R5", "crc_error pulses on bad checksum", err_count - e0, 1);
    chk(!synced, "R5", "synced after bad checksum", int'(synced), 0);
    w0 = wr_count;
    send_pkt(mk_id(4), 1'b0, 164, 1'b0);
    chk(wr_count == w0, "R5", "writes after checksum error", wr_count - w0, 0);

    // R6 out-of-sequence line
    send_pkt(mk_id(0), 1'b0, 164, 1'b0);
    send_pkt(mk_id(1), 1'b0, 164, 1'b0);
    chk(synced, "R6", "synced before skip", int'(synced), 1);
    w0 = wr_count;
    send_pkt(mk_id(3), 1'b0, 164, 1'b0);
    chk(wr_count == w0 && !synced, "R6", "skipped line writes", wr_count - w0, 0);
    send_pkt(mk_id(4), 1'b0, 164, 1'b0);
    chk(wr_count == w0, "R6", "writes after skip", wr_count - w0, 0);
    chk(done_count == d0, "R6", "no frame_done for broken frame", done_count - d0, 0);

    // resync on a fresh frame
    send_frame(1'b0);
    chk(done_count == d0 + 1, "R7", "frame_done after resync", done_count - d0, 1);
    cmp_mem("R3");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule